// File: doc/BRIEF.md
# Memory Protection Rule Register Bank

This block stores the rule set of a physical memory protection unit: up to sixteen entries, each with an 8-bit configuration byte and an address word, plus a small security control register with three flags (lockdown, whitelist and lock bypass). Software reaches it through one CSR-style port. A write names a target class and an index. Configuration bytes are written in packed words of XLEN/8 bytes, address registers one at a time, and the security register as a single word. Reads come back combinationally on the same port.

Lock rules decide which writes take effect. An entry whose lock bit is set is frozen while bypass is clear. A locked entry in top-of-range mode also freezes the address register of the entry just below it, because that register is its lower bound. The lockdown and whitelist flags can only be set. Bypass cannot be switched on while any entry carries a lock bit. Every entry's configuration and address, and the three flags, are driven out in parallel for the range decoder. A one-cycle `rulesChanged` pulse tells downstream permission caches to flush.

Top module: `memprot_regbank`

## Requirements
- R1: After reset, every configuration byte, every address register and all three security flags are zero, and `rulesChanged` is low.
- R2: Configuration byte layout: read permission in bit 0, write in bit 1, execute in bit 2, match mode in bits 4:3 (00 off, 01 top-of-range, 10 and 11 other modes), lock in bit 7. With `csrSel`=0, byte i of the data word (bits 8i+7:8i) goes to entry `csrIdx`*(XLEN/8)+i, and a read returns the bytes packed the same way.
- R3: An entry is locked when its lock bit is 1 and the bypass flag is 0. A configuration write to a locked entry leaves its byte unchanged. Other bytes in the same word are still written.
- R4: While the lockdown flag is 0, a configuration byte with write=1 and read=0 is discarded and that entry keeps its old byte. While lockdown is 1, such a byte is stored.
- R5: An address write (`csrSel`=1, entry `csrIdx`) is ignored when that entry is locked, or when the next entry is locked and in top-of-range mode. A locked next entry in any other mode does not block it.
- R6: While the bypass flag is 1, no entry is treated as locked, and configuration and address writes to entries with lock bit set take effect.
- R7: Security word (`csrSel`=2): bit 0 lockdown, bit 1 whitelist, bit 2 bypass. A write can set lockdown or whitelist but never clear them.
- R8: Bypass can always be cleared, but a write cannot raise it from 0 to 1 while any entry has its lock bit set.
- R9: A configuration word index beyond the last entry, an address index of NUM_ENT or above, and `csrSel`=3 all read as zero, and writes to them change nothing.
- R10: `rulesChanged` is high for exactly the cycle after a write that alters a stored configuration byte or address, or that sets lockdown or whitelist. A rewrite of identical values, an ignored write, or a change of bypass alone does not raise it.
- R11: Read data follows `csrSel`/`csrIdx` within the same cycle. A write is visible on the outputs and on read-back after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Write strobe for the addressed register |
| csrSel | input | 2 | Target: 0 config word, 1 address, 2 security, 3 none |
| csrIdx | input | IDX_W | Config word index or address register index |
| csrWrData | input | XLEN | Write data |
| csrRdData | output | XLEN | Combinational read data |
| entCfg | output | NUM_ENT*8 | All configuration bytes, entry e at bits 8e+7:8e |
| entAddr | output | NUM_ENT*XLEN | All address registers, entry e at word e |
| lockdown | output | 1 | Lockdown flag |
| whitelist | output | 1 | Whitelist flag |
| lockBypass | output | 1 | Lock bypass flag |
| rulesChanged | output | 1 | One-cycle pulse after a rule change |

## Verification
Read data is due in the same cycle the select and index settle. The bench sets them on a falling edge and samples a moment later. A write's effect on the stored registers, the flags and `rulesChanged` is due after exactly one rising edge. Write strobes are driven for one cycle from a falling edge, and all three results are sampled on the following falling edge, the only cycle in which the pulse is high. The next write's pulse therefore cannot be mistaken for the previous one.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_NONE = 2'd3
  } csrSel_e;

  localparam int CFG_R    = 0;
  localparam int CFG_W    = 1;
  localparam int CFG_A_LO = 3;
  localparam int CFG_L    = 7;

  localparam logic [1:0] MODE_TOR = 2'b01;

  localparam int SEC_MML  = 0;
  localparam int SEC_MMWP = 1;
  localparam int SEC_RLB  = 2;

  typedef struct packed {
    logic secWr;
    logic mmlSet;
    logic mmwpSet;
    logic rlbNext;
  } secStrobe_t;
endpackage

// File: rtl/mpr_ctrl.sv
module mpr_ctrl
  import mpr_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int XLEN    = 32,
  parameter int IDX_W   = 6
) (
  input  logic                   csrWrEn,
  input  logic [1:0]             csrSel,
  input  logic [IDX_W-1:0]       csrIdx,
  input  logic [XLEN-1:0]        csrWrData,
  input  logic [NUM_ENT-1:0]     lockBits,
  input  logic [NUM_ENT*2-1:0]   modeBits,
  input  logic                   rlbQ,
  input  logic                   mmlQ,
  output logic [NUM_ENT-1:0]     cfgWe,
  output logic [NUM_ENT*8-1:0]   cfgNew,
  output logic [NUM_ENT-1:0]     addrWe,
  output secStrobe_t             secStb
);
  localparam int BPW = XLEN / 8;

  logic wrCfg, wrAddr;
  logic [NUM_ENT-1:0] lockedVec, resvEnc, nextBlk;

  assign wrCfg  = csrWrEn && (csrSel == SEL_CFG);
  assign wrAddr = csrWrEn && (csrSel == SEL_ADDR);

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    // effective lock: bypass suppresses every lock bit
    assign lockedVec[e] = lockBits[e] & ~rlbQ;
    assign cfgNew[e*8 +: 8] = csrWrData[(e % BPW)*8 +: 8];
    // write-only permission is reserved unless lockdown is active
    assign resvEnc[e] = cfgNew[e*8 + CFG_W] & ~cfgNew[e*8 + CFG_R] & ~mmlQ;
    assign cfgWe[e] = wrCfg && (csrIdx == IDX_W'(e / BPW)) &&
                      !lockedVec[e] && !resvEnc[e];
    if (e + 1 < NUM_ENT) begin : g_nxt
      // a locked top-of-range neighbour owns this address as its base
      assign nextBlk[e] = lockedVec[e+1] && (modeBits[(e+1)*2 +: 2] == MODE_TOR);
    end else begin : g_top
      assign nextBlk[e] = 1'b0;
    end
    assign addrWe[e] = wrAddr && (csrIdx == IDX_W'(e)) &&
                       !lockedVec[e] && !nextBlk[e];
  end

  always_comb begin
    secStb.secWr   = csrWrEn && (csrSel == SEL_SEC);
    secStb.mmlSet  = csrWrData[SEC_MML];
    secStb.mmwpSet = csrWrData[SEC_MMWP];
    // bypass may only rise when no lock bit is present anywhere
    secStb.rlbNext = csrWrData[SEC_RLB] & (rlbQ | ~(|lockBits));
  end
endmodule

// File: rtl/mpr_datapath.sv
module mpr_datapath
  import mpr_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int XLEN    = 32,
  parameter int IDX_W   = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_ENT-1:0]        cfgWe,
  input  logic [NUM_ENT*8-1:0]      cfgNew,
  input  logic [NUM_ENT-1:0]        addrWe,
  input  logic [XLEN-1:0]           csrWrData,
  input  secStrobe_t                secStb,
  input  logic [1:0]                csrSel,
  input  logic [IDX_W-1:0]          csrIdx,
  output logic [XLEN-1:0]           csrRdData,
  output logic [NUM_ENT*8-1:0]      cfgQ,
  output logic [NUM_ENT*XLEN-1:0]   addrQ,
  output logic                      mmlQ,
  output logic                      mmwpQ,
  output logic                      rlbQ,
  output logic [NUM_ENT-1:0]        lockBits,
  output logic [NUM_ENT*2-1:0]      modeBits,
  output logic                      rulesChanged
);
  localparam int BPW = XLEN / 8;

  logic [NUM_ENT-1:0] cfgDiff, addrDiff;
  logic secDiff;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ[e*8 +: 8] <= '0;
      end else if (cfgWe[e]) begin
        cfgQ[e*8 +: 8] <= cfgNew[e*8 +: 8];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ[e*XLEN +: XLEN] <= '0;
      end else if (addrWe[e]) begin
        addrQ[e*XLEN +: XLEN] <= csrWrData;
      end
    end

    assign cfgDiff[e]  = cfgWe[e] && (cfgNew[e*8 +: 8] != cfgQ[e*8 +: 8]);
    assign addrDiff[e] = addrWe[e] && (csrWrData != addrQ[e*XLEN +: XLEN]);
    assign lockBits[e] = cfgQ[e*8 + CFG_L];
    assign modeBits[e*2 +: 2] = cfgQ[e*8 + CFG_A_LO +: 2];
  end

  assign secDiff = secStb.secWr &&
                   ((secStb.mmlSet & ~mmlQ) | (secStb.mmwpSet & ~mmwpQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mmlQ         <= 1'b0;
      mmwpQ        <= 1'b0;
      rlbQ         <= 1'b0;
      rulesChanged <= 1'b0;
    end else begin
      if (secStb.secWr) begin
        mmlQ  <= mmlQ | secStb.mmlSet;
        mmwpQ <= mmwpQ | secStb.mmwpSet;
        rlbQ  <= secStb.rlbNext;
      end
      rulesChanged <= (|cfgDiff) | (|addrDiff) | secDiff;
    end
  end

  always_comb begin
    csrRdData = '0;
    unique case (csrSel)
      SEL_CFG: begin
        for (int e = 0; e < NUM_ENT; e++) begin
          if (csrIdx == IDX_W'(e / BPW)) csrRdData[(e % BPW)*8 +: 8] = cfgQ[e*8 +: 8];
        end
      end
      SEL_ADDR: begin
        for (int e = 0; e < NUM_ENT; e++) begin
          if (csrIdx == IDX_W'(e)) csrRdData = addrQ[e*XLEN +: XLEN];
        end
      end
      SEL_SEC: begin
        csrRdData[SEC_MML]  = mmlQ;
        csrRdData[SEC_MMWP] = mmwpQ;
        csrRdData[SEC_RLB]  = rlbQ;
      end
      default: csrRdData = '0;
    endcase
  end
endmodule

// File: rtl/memprot_regbank.sv
module memprot_regbank
  import mpr_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int XLEN    = 32,
  parameter int IDX_W   = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    csrWrEn,
  input  logic [1:0]              csrSel,
  input  logic [IDX_W-1:0]        csrIdx,
  input  logic [XLEN-1:0]         csrWrData,
  output logic [XLEN-1:0]         csrRdData,
  output logic [NUM_ENT*8-1:0]    entCfg,
  output logic [NUM_ENT*XLEN-1:0] entAddr,
  output logic                    lockdown,
  output logic                    whitelist,
  output logic                    lockBypass,
  output logic                    rulesChanged
);
  logic [NUM_ENT-1:0]   cfgWe, addrWe, lockBits;
  logic [NUM_ENT*8-1:0] cfgNew;
  logic [NUM_ENT*2-1:0] modeBits;
  secStrobe_t           secStb;

  mpr_ctrl #(.NUM_ENT(NUM_ENT), .XLEN(XLEN), .IDX_W(IDX_W)) uCtrl (
    .csrWrEn   (csrWrEn),
    .csrSel    (csrSel),
    .csrIdx    (csrIdx),
    .csrWrData (csrWrData),
    .lockBits  (lockBits),
    .modeBits  (modeBits),
    .rlbQ      (lockBypass),
    .mmlQ      (lockdown),
    .cfgWe     (cfgWe),
    .cfgNew    (cfgNew),
    .addrWe    (addrWe),
    .secStb    (secStb)
  );

  mpr_datapath #(.NUM_ENT(NUM_ENT), .XLEN(XLEN), .IDX_W(IDX_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWe        (cfgWe),
    .cfgNew       (cfgNew),
    .addrWe       (addrWe),
    .csrWrData    (csrWrData),
    .secStb       (secStb),
    .csrSel       (csrSel),
    .csrIdx       (csrIdx),
    .csrRdData    (csrRdData),
    .cfgQ         (entCfg),
    .addrQ        (entAddr),
    .mmlQ         (lockdown),
    .mmwpQ        (whitelist),
    .rlbQ         (lockBypass),
    .lockBits     (lockBits),
    .modeBits     (modeBits),
    .rulesChanged (rulesChanged)
  );
endmodule

// File: rtl/memprot_regbank_chk.sv
module memprot_regbank_chk #(
  parameter int NUM_ENT = 16,
  parameter int XLEN    = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    csrWrEn,
  input logic [NUM_ENT*8-1:0]    entCfg,
  input logic [NUM_ENT*XLEN-1:0] entAddr,
  input logic                    lockdown,
  input logic                    whitelist,
  input logic                    lockBypass,
  input logic                    rulesChanged
);
  logic anyLock;
  always_comb begin
    anyLock = 1'b0;
    for (int e = 0; e < NUM_ENT; e++) anyLock = anyLock | entCfg[e*8+7];
  end

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    // R3
    cfg_lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (entCfg[e*8+7] && !lockBypass) |=> $stable(entCfg[e*8 +: 8]));
    // R5
    addr_lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (entCfg[e*8+7] && !lockBypass) |=> $stable(entAddr[e*XLEN +: XLEN]));
    // R4
    no_resv_enc_chk: assert property (@(posedge clk) disable iff (!rstN)
      !lockdown |-> !(entCfg[e*8+1] && !entCfg[e*8]));
  end

  // R7
  lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockdown |=> lockdown);
  // R7
  whitelist_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    whitelist |=> whitelist);
  // R8
  bypass_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockBypass) |-> !$past(anyLock));
  // R10
  pulse_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    rulesChanged |-> $past(csrWrEn));
endmodule

bind memprot_regbank memprot_regbank_chk #(.NUM_ENT(NUM_ENT), .XLEN(XLEN)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .csrWrEn      (csrWrEn),
  .entCfg       (entCfg),
  .entAddr      (entAddr),
  .lockdown     (lockdown),
  .whitelist    (whitelist),
  .lockBypass   (lockBypass),
  .rulesChanged (rulesChanged)
);

// File: tb/tb_memprot_regbank.sv
module tb_memprot_regbank;
  localparam int N  = 16;
  localparam int XL = 32;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrWrEn = 1'b0;
  logic [1:0] csrSel = 2'd0;
  logic [IW-1:0] csrIdx = '0;
  logic [XL-1:0] csrWrData = '0;
  logic [XL-1:0] csrRdData;
  logic [N*8-1:0] entCfg;
  logic [N*XL-1:0] entAddr;
  logic lockdown, whitelist, lockBypass, rulesChanged;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  memprot_regbank #(.NUM_ENT(N), .XLEN(XL), .IDX_W(IW)) dut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrSel(csrSel), .csrIdx(csrIdx),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .entCfg(entCfg), .entAddr(entAddr),
    .lockdown(lockdown), .whitelist(whitelist), .lockBypass(lockBypass),
    .rulesChanged(rulesChanged)
  );

  task automatic check(input string tag, input logic [N*XL-1:0] act, input logic [N*XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    csrWrEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive one write for one cycle; returns on the falling edge after the capturing edge
  task automatic doWrite(input logic [1:0] sel, input int idx, input logic [XL-1:0] data);
    @(negedge clk);
    csrWrEn = 1'b1;
    csrSel = sel;
    csrIdx = IW'(idx);
    csrWrData = data;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] sel, input int idx, output logic [XL-1:0] rd);
    csrSel = sel;
    csrIdx = IW'(idx);
    #1;
    rd = csrRdData;
  endtask

  function automatic logic [7:0] cfgOf(input int e);
    return entCfg[e*8 +: 8];
  endfunction

  function automatic logic [XL-1:0] addrOf(input int e);
    return entAddr[e*XL +: XL];
  endfunction

  task automatic tReset();
    logic [XL-1:0] rd;
    check("R1 cfg", entCfg, '0);
    check("R1 addr", entAddr, '0);
    check("R1 flags", {lockdown, whitelist, lockBypass, rulesChanged}, '0);
    doRead(2'd2, 0, rd);
    check("R1 sec read", rd, '0);
  endtask

  task automatic tCfgMap();
    logic [XL-1:0] rd;
    doWrite(2'd0, 1, 32'h0B0D_0103);
    check("R2 entry4", cfgOf(4), 8'h03);
    check("R2 entry5", cfgOf(5), 8'h01);
    check("R2 entry6", cfgOf(6), 8'h0D);
    check("R2 entry7", cfgOf(7), 8'h0B);
    check("R10 pulse on change", rulesChanged, 1'b1);
    doRead(2'd0, 1, rd);
    check("R11 packed readback", rd, 32'h0B0D_0103);
    doWrite(2'd0, 1, 32'h0B0D_0103);
    check("R10 no pulse same value", rulesChanged, 1'b0);
  endtask

  task automatic tReserved();
    doWrite(2'd0, 0, 32'h0003_0201);
    check("R4 entry0 kept", cfgOf(0), 8'h01);
    check("R4 entry1 discarded", cfgOf(1), 8'h00);
    check("R4 entry2 kept", cfgOf(2), 8'h03);
  endtask

  task automatic tAddr();
    logic [XL-1:0] rd;
    doWrite(2'd1, 3, 32'h0000_1234);
    check("R11 addr3 out", addrOf(3), 32'h1234);
    check("R10 addr pulse", rulesChanged, 1'b1);
    doRead(2'd1, 3, rd);
    check("R11 addr3 read", rd, 32'h1234);
  endtask

  task automatic tLock();
    logic [XL-1:0] rd;
    // entry8 R, entry9 locked TOR, entry10 off, entry11 locked off
    doWrite(2'd0, 2, 32'h8000_8901);
    doWrite(2'd0, 2, 32'h0303_0303);
    doRead(2'd0, 2, rd);
    check("R3 locked bytes held", rd, 32'h8003_8903);
    doWrite(2'd1, 8, 32'h88);
    check("R5 next locked TOR blocks", addrOf(8), 32'h0);
    check("R10 no pulse ignored", rulesChanged, 1'b0);
    doWrite(2'd1, 9, 32'h99);
    check("R5 own lock blocks", addrOf(9), 32'h0);
    doWrite(2'd1, 10, 32'hAA);
    check("R5 next locked off allows", addrOf(10), 32'hAA);
    doWrite(2'd1, 7, 32'h77);
    check("R5 unlocked next allows", addrOf(7), 32'h77);
    doWrite(2'd2, 0, 32'h4);
    check("R8 bypass refused", lockBypass, 1'b0);
  endtask

  task automatic tBypass();
    doReset();
    doWrite(2'd2, 0, 32'h4);
    check("R7 bypass set", lockBypass, 1'b1);
    check("R10 no pulse bypass only", rulesChanged, 1'b0);
    doWrite(2'd0, 0, 32'h0000_0081);
    doWrite(2'd0, 0, 32'h0000_0003);
    check("R6 cfg write through lock", cfgOf(0), 8'h03);
    doWrite(2'd0, 0, 32'h0000_0081);
    doWrite(2'd1, 0, 32'h55);
    check("R6 addr write through lock", addrOf(0), 32'h55);
    doWrite(2'd2, 0, 32'h0);
    check("R8 bypass clear", lockBypass, 1'b0);
    doWrite(2'd0, 0, 32'h0000_0003);
    check("R3 lock active again", cfgOf(0), 8'h81);
    doWrite(2'd2, 0, 32'h4);
    check("R8 no rise with lock", lockBypass, 1'b0);
  endtask

  task automatic tSticky();
    logic [XL-1:0] rd;
    doReset();
    doWrite(2'd2, 0, 32'h1);
    check("R7 lockdown set", lockdown, 1'b1);
    check("R10 pulse lockdown", rulesChanged, 1'b1);
    doWrite(2'd2, 0, 32'h0);
    check("R7 lockdown sticky", lockdown, 1'b1);
    check("R10 no pulse no toggle", rulesChanged, 1'b0);
    doWrite(2'd2, 0, 32'h2);
    check("R7 whitelist set", whitelist, 1'b1);
    doRead(2'd2, 0, rd);
    check("R7 sec read", rd, 32'h3);
    doWrite(2'd0, 0, 32'h0000_0002);
    check("R4 allowed under lockdown", cfgOf(0), 8'h02);
  endtask

  task automatic tOob();
    logic [XL-1:0] rd;
    logic [N*8-1:0] cfgBefore;
    logic [N*XL-1:0] addrBefore;
    cfgBefore = entCfg;
    addrBefore = entAddr;
    doWrite(2'd0, 4, 32'hFFFF_FFFF);
    check("R9 cfg oob no pulse", rulesChanged, 1'b0);
    doWrite(2'd1, 16, 32'hFFFF_FFFF);
    doWrite(2'd3, 0, 32'hFFFF_FFFF);
    check("R9 cfg unchanged", entCfg, cfgBefore);
    check("R9 addr unchanged", entAddr, addrBefore);
    doRead(2'd0, 4, rd);
    check("R9 cfg oob read", rd, '0);
    doRead(2'd1, 16, rd);
    check("R9 addr oob read", rd, '0);
    doRead(2'd3, 0, rd);
    check("R9 sel3 read", rd, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCfgMap();
    tReserved();
    tAddr();
    tLock();
    tOob();
    tBypass();
    tSticky();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule